// File: doc/BRIEF.md
# Latency-Programmable Burst Read Sequencer

This block feeds the data phase of a bus target during a burst read from a synchronous, memory-like backend. A start pulse loads a DWORD start address. The block then issues one fetch strobe per cycle to the backend, and the fetch address advances by one after each strobe. A 3-bit latency setting tells the block how many cycles the backend needs to answer a fetch. The block uses it to pick each returned word off the backend data bus in the right cycle.

Returned words go into a small buffer. The buffer presents them to the bus side as a valid/ready stream: `out_valid` is the target-ready indication and `mst_ready` is the master's ready. A word moves only in a cycle where both are high. While `out_valid` is high and `mst_ready` is low, the head word and `out_valid` stay unchanged.

Either side can pause the burst. If `mst_ready` or `be_ready` is low in a cycle, the fetch strobe is low in the next cycle. The strobe in the cycle where `be_ready` first drops still goes out, so the backend must answer one more word. The block stops fetching while the words already in flight plus the buffered words would fill the buffer. A stop pulse ends the burst and throws away all buffered and in-flight words.

Top module: `latency_read_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fetch` and `out_valid` are low.
- R2: The first fetch after a start pulse carries `start_addr`. Each later fetch carries the previous fetch address plus one, wrapping modulo 2^22.
- R3: If `be_ready` is low in a cycle, `fetch` is low in the next cycle. A fetch already high in the cycle where `be_ready` drops still takes place, which is one more DWORD.
- R4: If `mst_ready` is low in a cycle, `fetch` is low in the next cycle.
- R5: With latency L (0 to 7), the word on `be_data` L cycles after a fetch is the reply to that fetch. L = 0 means the reply is in the same cycle as the strobe.
- R6: Words reach the bus side in strict fetch-address order, with none lost or repeated, across any pattern of master and backend pauses.
- R7: `out_valid` is high only when a buffered word exists. While `out_valid` is high and `mst_ready` is low, `out_valid` stays high and `out_data` is held.
- R8: Fetches issued minus words taken by the bus never exceeds the buffer depth `DEPTH` (default 8).
- R9: In the cycle after a stop pulse, `fetch` and `out_valid` are low. Replies that were in flight when the stop pulse arrived never reach the bus side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lat_sel | input | 3 | Backend read latency in cycles; held constant during a burst |
| start | input | 1 | One-cycle pulse: load the address and begin a burst |
| start_addr | input | 22 | DWORD start address (byte address bits 23:2) |
| stop | input | 1 | One-cycle pulse: end the burst and flush |
| be_ready | input | 1 | Backend can accept fetches |
| fetch | output | 1 | Fetch strobe to the backend |
| fetch_addr | output | 22 | DWORD address of the current fetch |
| be_data | input | 32 | Read data returned by the backend |
| out_valid | output | 1 | Target-ready: a word is offered to the bus |
| out_data | output | 32 | Offered word |
| mst_ready | input | 1 | Master ready; a word moves when this and `out_valid` are both high |

## Verification
The assertions assume these things about the inputs: `lat_sel` does not change inside a burst, `start` and `stop` are single-cycle pulses that never occur together, and the backend answers every fetch exactly L cycles later. The bench uses a backend model that records each fetch address and drives its reply on `be_data` after the programmed latency. It changes the latency only while the block is idle. It pauses `mst_ready` and `be_ready` with fixed periodic patterns and with directed drops, including a long latency that makes the buffer limit hold back fetches.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_st_t;
endpackage

// File: rtl/rdseq_lat_pipe.sv
module rdseq_lat_pipe #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [LAT_W-1:0] lat,
  input  logic             fetch,
  output logic             arrive
);
  localparam int MAXLAT = (1 << LAT_W) - 1;

  logic [MAXLAT-1:0] tag;

  // tag[k] marks a fetch issued k+1 cycles ago
  always_ff @(posedge clk) begin
    if (!rst_n || flush) tag <= '0;
    else                 tag <= {tag[MAXLAT-2:0], fetch};
  end

  assign arrive = (lat == '0) ? fetch : tag[lat - LAT_W'(1)];
endmodule

// File: rtl/rdseq_skid_fifo.sv
module rdseq_skid_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          din,
  input  logic                       pop,
  output logic                       valid,
  output logic [DATA_W-1:0]          dout,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign do_push = push && (cnt < CW'(DEPTH));
  assign do_pop  = pop && valid;
  assign valid   = (cnt != '0);
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  // R7: an offered word is held while the bus side stalls
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !pop && !flush |=> valid && $stable(dout));
endmodule

// File: rtl/rdseq_fetch_ctl.sv
module rdseq_fetch_ctl
  import rdseq_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DEPTH  = 8,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              be_ready,
  input  logic              mst_ready,
  input  logic [CW-1:0]     fifo_cnt,
  input  logic              arrive,
  output logic              fetch,
  output logic [ADDR_W-1:0] fetch_addr
);
  run_st_t       st;
  logic [CW-1:0] pend;
  logic [CW:0]   resv;
  logic          space;

  // words owed to the buffer: stored, in flight, and the current fetch
  assign resv  = (CW+1)'(fifo_cnt) + (CW+1)'(pend) + (CW+1)'(fetch);
  assign space = resv < (CW+1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      fetch      <= 1'b0;
      pend       <= '0;
      fetch_addr <= '0;
    end else if (start) begin
      st         <= ST_RUN;
      fetch      <= 1'b0;
      pend       <= '0;
      fetch_addr <= start_addr;
    end else if (stop) begin
      st    <= ST_IDLE;
      fetch <= 1'b0;
      pend  <= '0;
    end else begin
      fetch <= (st == ST_RUN) && be_ready && mst_ready && space;
      if (fetch) fetch_addr <= fetch_addr + ADDR_W'(1);
      if (fetch && !arrive)      pend <= pend + CW'(1);
      else if (arrive && !fetch) pend <= pend - CW'(1);
    end
  end

  a_r3_backend_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !be_ready |=> !fetch);
  a_r4_master_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_ready |=> !fetch);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ((CW+1)'(fifo_cnt) + (CW+1)'(pend)) <= (CW+1)'(DEPTH));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fetch && !start && !stop |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));
endmodule

// File: rtl/latency_read_seq.sv
module latency_read_seq #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  lat_sel,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              stop,
  input  logic              be_ready,
  output logic              fetch,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] be_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              mst_ready
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          flush, arrive;
  logic [CW-1:0] fifo_cnt;

  assign flush = start || stop;

  rdseq_fetch_ctl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW(CW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .start_addr(start_addr), .be_ready(be_ready), .mst_ready(mst_ready),
    .fifo_cnt(fifo_cnt), .arrive(arrive), .fetch(fetch), .fetch_addr(fetch_addr)
  );

  rdseq_lat_pipe #(.LAT_W(LAT_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lat(lat_sel),
    .fetch(fetch), .arrive(arrive)
  );

  rdseq_skid_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(arrive), .din(be_data),
    .pop(mst_ready), .valid(out_valid), .dout(out_data), .cnt(fifo_cnt)
  );

  a_r9_stop_flush: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !fetch && !out_valid);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !fetch && !out_valid);
endmodule

// File: tb/latency_read_seq_bench.sv
module latency_read_seq_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lat_sel = '0;
  logic        start = 1'b0, stop = 1'b0;
  logic [21:0] start_addr = '0;
  logic        be_ready = 1'b0, mst_ready = 1'b0;
  logic        fetch, out_valid;
  logic [21:0] fetch_addr;
  logic [31:0] be_data, out_data;

  int checks = 0, errors = 0, cyc = 0, rcv = 0;
  logic [31:0] exp_q [$];
  logic [21:0] hist [1:7];
  logic [21:0] exp_faddr = '0;
  int fetch_cnt = 0, pop_cnt = 0;
  logic prev_mr = 1'b1, prev_br = 1'b1;

  always #2.5 clk = ~clk;

  latency_read_seq u_latency_read_seq (
    .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .start(start),
    .start_addr(start_addr), .stop(stop), .be_ready(be_ready), .fetch(fetch),
    .fetch_addr(fetch_addr), .be_data(be_data), .out_valid(out_valid),
    .out_data(out_data), .mst_ready(mst_ready)
  );

  function automatic logic [31:0] pat(input logic [21:0] a);
    return 32'hC3A0_0000 ^ {a[9:0], a};
  endfunction

  // backend model: reply to a fetch lat_sel cycles later
  always @(posedge clk) begin
    hist[1] <= fetch_addr;
    for (int k = 2; k <= 7; k++) hist[k] <= hist[k-1];
  end
  assign be_data = (lat_sel == 3'd0) ? pat(fetch_addr) : pat(hist[lat_sel]);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (start) begin
        exp_faddr = start_addr;
        fetch_cnt = 0;
        pop_cnt   = 0;
      end
      if (!prev_br) check(!fetch, "R3", 32'(fetch), 0);
      if (!prev_mr) check(!fetch, "R4", 32'(fetch), 0);
      if (fetch) begin
        check(fetch_addr == exp_faddr, "R2", 32'(fetch_addr), 32'(exp_faddr));
        exp_faddr = exp_faddr + 22'd1;
        fetch_cnt++;
      end
      check(fetch_cnt - pop_cnt <= DEPTH, "R8", 32'(fetch_cnt - pop_cnt), DEPTH);
      if (out_valid && mst_ready) begin
        pop_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R9 R6 unexpected word", out_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R5 R6 data order", out_data, e);
          rcv++;
        end
      end
      prev_mr = mst_ready;
      prev_br = be_ready;
    end
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // mode 0: free flow; 1: directed backend drop; 2: periodic pauses on both sides
  task automatic burst(input logic [21:0] a, input logic [2:0] lat, input int n, input int mode);
    int t;
    lat_sel = lat;
    for (int i = 0; i < n; i++) exp_q.push_back(pat(a + 22'(i)));
    rcv = 0;
    start_addr = a;
    start = 1'b1;
    step();
    start = 1'b0;
    t = 0;
    while (rcv < n) begin
      case (mode)
        0: begin mst_ready = 1'b1; be_ready = 1'b1; end
        1: begin
          mst_ready = 1'b1;
          be_ready  = !(t >= 20 && t < 25);
        end
        default: begin
          mst_ready = (t % 5) >= 2;
          be_ready  = (t % 7) != 3;
        end
      endcase
      if (mode == 1 && t == 20) begin
        @(negedge clk);
        check(fetch == 1'b1, "R3 one more DWORD", 32'(fetch), 1);
      end
      step();
      t++;
    end
    mst_ready = 1'b0;
    stop = 1'b1;
    step();
    stop = 1'b0;
    @(negedge clk);
    check(!fetch && !out_valid, "R9 stop flush", {fetch, out_valid}, 0);
    step();
    check(exp_q.size() == 0, "R6 all words delivered", exp_q.size(), 0);
  endtask

  initial begin
    step();
    @(negedge clk);
    check(!fetch && !out_valid, "R1 in reset", {fetch, out_valid}, 0);
    step();
    rst_n = 1'b1;
    @(negedge clk);
    check(!fetch && !out_valid, "R1 after reset", {fetch, out_valid}, 0);
    step();
    burst(22'h000100, 3'd0, 20, 0);
    burst(22'h001000, 3'd3, 40, 1);
    burst(22'h020000, 3'd7, 50, 2);
    burst(22'h3FFFFE, 3'd2, 6, 0);
    burst(22'h000040, 3'd1, 30, 2);
    burst(22'h00ABC0, 3'd7, 30, 0);
    burst(22'h000500, 3'd0, 25, 2);
    // stop mid-flight: replies already in flight must not reach the bus
    lat_sel = 3'd5;
    start_addr = 22'h000200;
    start = 1'b1;
    step();
    start = 1'b0;
    mst_ready = 1'b0;
    be_ready = 1'b1;
    mst_ready = 1'b1;
    step();
    mst_ready = 1'b0;
    step();
    step();
    stop = 1'b1;
    step();
    stop = 1'b0;
    mst_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!out_valid && !fetch, "R9 late replies discarded", {fetch, out_valid}, 0);
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule